// File: doc/BRIEF.md
# Lockable Set-Associative Cache Tag Array

This block keeps the tag state of a set-associative cache: for every way of every set it stores a valid flag, a dirty flag, a lock flag, a stored tag and a replacement rank counter. A client issues one command at a time on a valid/ready port: read, write, lock, unlock, invalidate (with an optional flush flag), or invalidate-all. The block answers on a registered response port. The response says whether the access hit, which way was used, whether a new line was allocated, whether the access must bypass the cache, and whether a dirty line must be written back, along with that line's address. The data storage, the refill path and the writeback transfer belong to the client. The block only names the work those parts must do.

The replacement rank of a way rises to the way count when the way is used. It falls to zero when the way is invalidated. Ranks between the old and new positions shift by one so that the order stays consistent. The victim on a miss is the unlocked way with the lowest rank. If every way of the set is locked, there is no victim and the access bypasses the cache. Addresses in the top region of the address space, and every address while the global disable input is high, are not cacheable. They change no state.

Top module: `ctag_array`

## Requirements
- R1: The set index is address bits [OFF_W +: SET_W] (OFF_W = log2 of the line size, SET_W = log2 of the set count), and the tag is the bits above them. An access hits only when a way of that set is valid and its stored tag equals the address tag. A hit reports rsp_hit=1 and the hit way in rsp_way.
- R2: A read (op 0) that misses and has a victim allocates the victim (valid=1, dirty=0, new tag). It reports rsp_alloc=1 with that way, and a later read of the same line hits in that way.
- R3: The victim is the unlocked way with the smallest rank. On a tie the lowest way index wins.
- R4: When every way of the set is locked, a read, write or lock that misses reports rsp_bypass=1 and rsp_alloc=0, and it changes no state.
- R5: Using a way (a hit, or an allocation by read, write or lock) decrements the rank of every way in the set whose rank is above the used way's rank. It then sets the used way's rank to the way count.
- R6: An invalidate (op 4) that hits adds one to the rank of every other way whose rank is nonzero and below the hit way's rank, and it sets the hit way's rank to 0. It clears that way's valid, dirty and lock flags. It reports rsp_wb=1 with the line address when the line was dirty and cmd_flush=1. An invalidate that misses changes nothing.
- R7: An invalidate-all (op 5) produces no response in the cycle after acceptance. It then gives one response per line, in set-major order (set 0 way 0 first), and each beat clears the line and sets its rank to 0. A beat reports rsp_wb=1 with the line address when the line was valid, dirty and cmd_flush was 1. rsp_last=1 marks the final beat. cmd_ready stays low until that beat.
- R8: An address at or above 0xFE000000, or any address while cache_dis=1, is non-cacheable. Read, write, lock, unlock and invalidate then report rsp_bypass=1 and rsp_hit=0, and they change no state.
- R9: A write (op 1) that hits sets dirty when cb_mode=1 and leaves dirty unchanged when cb_mode=0. A write that misses allocates a dirty line when cb_mode=1. With cb_mode=0 it bypasses and changes no state.
- R10: An allocation whose victim was valid and dirty reports rsp_wb=1, with the victim's old line address in rsp_wb_addr (offset bits zero), when cb_mode=1. It reports rsp_wb=0 when cb_mode=0.
- R11: Unlock (op 3) clears the lock flag of the hit way and leaves the ranks unchanged. On a miss it has no effect.
- R12: Lock (op 2) behaves as a read and also sets the lock flag of the hit or allocated way. A locked way is never chosen as victim.
- R13: After reset, cmd_ready=1 and rsp_valid=0, and every line is invalid, clean and unlocked with rank 0.
- R14: Every accepted command other than invalidate-all produces exactly one response with rsp_valid=1 and rsp_last=1, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | 0 read, 1 write, 2 lock, 3 unlock, 4 invalidate, 5 invalidate-all |
| cmd_addr | input | 32 | Byte address |
| cmd_flush | input | 1 | Request writeback of dirty lines on invalidate |
| cache_dis | input | 1 | Forces every address non-cacheable |
| cb_mode | input | 1 | Copy-back mode (0 = write-through) |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Access hit |
| rsp_bypass | output | 1 | Access must go to memory directly |
| rsp_alloc | output | 1 | A victim way was allocated |
| rsp_way | output | WAY_W | Hit, allocated or walked way |
| rsp_wb | output | 1 | A dirty line must be written back |
| rsp_wb_addr | output | 32 | Line address of that writeback |
| rsp_last | output | 1 | Final response of the command |

## Verification
A wrong rank, lock or valid flag shows up at the ports through the victim choice: the next miss in that set allocates a different way than the rank rules predict. So a rank error appears at most a few accesses later, as a wrong rsp_way or rsp_alloc. A wrong dirty flag appears at the next eviction or flush of that line, as a missing or extra rsp_wb. An invalidate-all walk exposes the whole array in one pass. The bench therefore runs a tight pool of tags over a few sets, so lines are evicted often, and compares every response field against a model.

// File: rtl/ctag_pkg.sv
package ctag_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_WRITE     = 3'd1,
        OP_LOCK      = 3'd2,
        OP_UNLOCK    = 3'd3,
        OP_INVAL     = 3'd4,
        OP_INVAL_ALL = 3'd5
    } op_e;

    function automatic int way_bits(input int ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction

endpackage

// File: rtl/ctag_nc_check.sv
module ctag_nc_check #(
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] NC_BASE = 32'hFE00_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dis,
    output logic              nc
);
    assign nc = dis || (addr >= ADDR_W'(NC_BASE));
endmodule

// File: rtl/ctag_way_select.sv
module ctag_way_select #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 23,
    parameter int RANK_W = 3,
    parameter int WAY_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0]             lck,
    input  logic [WAYS-1:0][RANK_W-1:0] rank,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            ltag,
    output logic [WAYS-1:0]             hit_vec,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic                        vic_ok,
    output logic [WAY_W-1:0]            vic_way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld[w] && (tags[w] == ltag);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    always_comb begin
        logic [RANK_W-1:0] best;
        best    = '0;
        vic_ok  = 1'b0;
        vic_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!lck[w] && (!vic_ok || rank[w] < best)) begin
                vic_ok  = 1'b1;
                vic_way = WAY_W'(w);
                best    = rank[w];
            end
        end
    end

    // R1: at most one way of a set can match a tag
    assert_hit_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R3: the victim is never a locked way
    assert_victim_unlocked_R3: assert property (@(posedge clk) disable iff (rst)
        vic_ok |-> !lck[vic_way]);

endmodule

// File: rtl/ctag_rank_update.sv
module ctag_rank_update #(
    parameter int WAYS   = 4,
    parameter int RANK_W = 3,
    parameter int WAY_W  = 2
) (
    input  logic [WAYS-1:0][RANK_W-1:0] cur,
    input  logic [WAY_W-1:0]            way,
    output logic [WAYS-1:0][RANK_W-1:0] mru,
    output logic [WAYS-1:0][RANK_W-1:0] inv
);
    logic [RANK_W-1:0] ref_rank;
    assign ref_rank = cur[way];

    for (genvar x = 0; x < WAYS; x++) begin : g_rank
        always_comb begin
            if (WAY_W'(x) == way) begin
                mru[x] = RANK_W'(WAYS);
                inv[x] = '0;
            end else begin
                mru[x] = (cur[x] > ref_rank) ? cur[x] - 1'b1 : cur[x];
                inv[x] = (cur[x] != '0 && cur[x] < ref_rank) ? cur[x] + 1'b1 : cur[x];
            end
        end
    end
endmodule

// File: rtl/ctag_array.sv
module ctag_array
    import ctag_pkg::*;
#(
    parameter int          SETS       = 16,
    parameter int          WAYS       = 4,
    parameter int          LINE_BYTES = 32,
    parameter logic [31:0] NC_BASE    = 32'hFE00_0000,
    localparam int         WAY_W      = way_bits(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_flush,
    input  logic              cache_dis,
    input  logic              cb_mode,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_bypass,
    output logic              rsp_alloc,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_wb,
    output logic [ADDR_W-1:0] rsp_wb_addr,
    output logic              rsp_last
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int RANK_W = $clog2(WAYS + 1);

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic              locked;
        logic [RANK_W-1:0] rank;
        logic [TAG_W-1:0]  tag;
    } line_t;

    typedef line_t [WAYS-1:0] set_t;

    set_t [SETS-1:0] ln_q;

    logic             ready_q, walking_q, wflush_q;
    logic [SET_W-1:0] walk_set_q;
    logic [WAY_W-1:0] walk_way_q;
    logic             walk_last;

    op_e              op;
    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] ltag;
    logic             accept, nc;
    set_t             cur;

    logic [WAYS-1:0]             s_vld, s_lck, hit_vec;
    logic [WAYS-1:0][RANK_W-1:0] s_rank, mru_r, inv_r;
    logic [WAYS-1:0][TAG_W-1:0]  s_tag;
    logic                        hit, vic_ok;
    logic [WAY_W-1:0]            hit_way, vic_way, tw;

    assign op        = op_e'(cmd_op);
    assign set_idx   = cmd_addr[OFF_W +: SET_W];
    assign ltag      = cmd_addr[ADDR_W-1 -: TAG_W];
    assign accept    = cmd_valid && ready_q;
    assign cmd_ready = ready_q;
    assign cur       = ln_q[set_idx];
    assign tw        = hit ? hit_way : vic_way;
    assign walk_last = (walk_set_q == SET_W'(SETS - 1)) && (walk_way_q == WAY_W'(WAYS - 1));

    for (genvar w = 0; w < WAYS; w++) begin : g_unpack
        assign s_vld[w]  = cur[w].valid;
        assign s_lck[w]  = cur[w].locked;
        assign s_rank[w] = cur[w].rank;
        assign s_tag[w]  = cur[w].tag;
    end

    ctag_nc_check #(.ADDR_W(ADDR_W), .NC_BASE(NC_BASE)) u_nc (
        .addr (cmd_addr),
        .dis  (cache_dis),
        .nc   (nc)
    );

    ctag_way_select #(.WAYS(WAYS), .TAG_W(TAG_W), .RANK_W(RANK_W), .WAY_W(WAY_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .vld     (s_vld),
        .lck     (s_lck),
        .rank    (s_rank),
        .tags    (s_tag),
        .ltag    (ltag),
        .hit_vec (hit_vec),
        .hit     (hit),
        .hit_way (hit_way),
        .vic_ok  (vic_ok),
        .vic_way (vic_way)
    );

    ctag_rank_update #(.WAYS(WAYS), .RANK_W(RANK_W), .WAY_W(WAY_W)) u_rank (
        .cur (s_rank),
        .way (tw),
        .mru (mru_r),
        .inv (inv_r)
    );

    // Decision for one addressed command
    set_t              nset;
    logic              upd, d_hit, d_byp, d_alloc, d_wb;
    logic [WAY_W-1:0]  d_way;
    logic [ADDR_W-1:0] d_wbaddr;

    always_comb begin
        logic use_way, alloc, is_wr, is_lk;
        nset     = cur;
        upd      = 1'b0;
        d_hit    = 1'b0;
        d_byp    = 1'b0;
        d_alloc  = 1'b0;
        d_way    = '0;
        d_wb     = 1'b0;
        d_wbaddr = '0;
        use_way  = 1'b0;
        alloc    = 1'b0;
        is_wr    = (op == OP_WRITE);
        is_lk    = (op == OP_LOCK);
        case (op)
            OP_READ, OP_WRITE, OP_LOCK: begin
                if (nc) begin
                    d_byp = 1'b1;
                end else if (hit) begin
                    d_hit   = 1'b1;
                    d_way   = hit_way;
                    use_way = 1'b1;
                    if (is_wr && cb_mode) nset[hit_way].dirty = 1'b1;
                    if (is_lk) nset[hit_way].locked = 1'b1;
                end else if (vic_ok && (!is_wr || cb_mode)) begin
                    alloc   = 1'b1;
                    use_way = 1'b1;
                end else begin
                    d_byp = 1'b1;
                end
                if (alloc) begin
                    d_alloc  = 1'b1;
                    d_way    = vic_way;
                    d_wb     = cur[vic_way].valid && cur[vic_way].dirty && cb_mode;
                    d_wbaddr = d_wb ? {cur[vic_way].tag, set_idx, {OFF_W{1'b0}}} : '0;
                    nset[vic_way].valid  = 1'b1;
                    nset[vic_way].dirty  = is_wr;
                    nset[vic_way].locked = is_lk;
                    nset[vic_way].tag    = ltag;
                end
                if (use_way) begin
                    upd = 1'b1;
                    for (int x = 0; x < WAYS; x++) nset[x].rank = mru_r[x];
                end
            end
            OP_UNLOCK: begin
                if (nc) begin
                    d_byp = 1'b1;
                end else if (hit) begin
                    d_hit = 1'b1;
                    d_way = hit_way;
                    upd   = 1'b1;
                    nset[hit_way].locked = 1'b0;
                end
            end
            OP_INVAL: begin
                if (nc) begin
                    d_byp = 1'b1;
                end else if (hit) begin
                    d_hit    = 1'b1;
                    d_way    = hit_way;
                    upd      = 1'b1;
                    d_wb     = cur[hit_way].dirty && cmd_flush;
                    d_wbaddr = d_wb ? {ltag, set_idx, {OFF_W{1'b0}}} : '0;
                    for (int x = 0; x < WAYS; x++) nset[x].rank = inv_r[x];
                    nset[hit_way].valid  = 1'b0;
                    nset[hit_way].dirty  = 1'b0;
                    nset[hit_way].locked = 1'b0;
                end
            end
            default: ;
        endcase
    end

    line_t wl;
    assign wl = ln_q[walk_set_q][walk_way_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            ln_q        <= '0;
            ready_q     <= 1'b1;
            walking_q   <= 1'b0;
            wflush_q    <= 1'b0;
            walk_set_q  <= '0;
            walk_way_q  <= '0;
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_bypass  <= 1'b0;
            rsp_alloc   <= 1'b0;
            rsp_way     <= '0;
            rsp_wb      <= 1'b0;
            rsp_wb_addr <= '0;
            rsp_last    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            if (walking_q) begin
                ln_q[walk_set_q][walk_way_q] <= '0;
                rsp_valid   <= 1'b1;
                rsp_hit     <= 1'b0;
                rsp_bypass  <= 1'b0;
                rsp_alloc   <= 1'b0;
                rsp_way     <= walk_way_q;
                rsp_wb      <= wl.valid && wl.dirty && wflush_q;
                rsp_wb_addr <= (wl.valid && wl.dirty && wflush_q)
                               ? {wl.tag, walk_set_q, {OFF_W{1'b0}}} : '0;
                rsp_last    <= walk_last;
                if (walk_last) begin
                    walking_q <= 1'b0;
                    ready_q   <= 1'b1;
                end else if (walk_way_q == WAY_W'(WAYS - 1)) begin
                    walk_way_q <= '0;
                    walk_set_q <= walk_set_q + 1'b1;
                end else begin
                    walk_way_q <= walk_way_q + 1'b1;
                end
            end else if (accept) begin
                if (op == OP_INVAL_ALL) begin
                    walking_q  <= 1'b1;
                    ready_q    <= 1'b0;
                    wflush_q   <= cmd_flush;
                    walk_set_q <= '0;
                    walk_way_q <= '0;
                end else begin
                    if (upd) ln_q[set_idx] <= nset;
                    rsp_valid   <= 1'b1;
                    rsp_hit     <= d_hit;
                    rsp_bypass  <= d_byp;
                    rsp_alloc   <= d_alloc;
                    rsp_way     <= d_way;
                    rsp_wb      <= d_wb;
                    rsp_wb_addr <= d_wbaddr;
                    rsp_last    <= 1'b1;
                end
            end
        end
    end

    // R7: no command is taken while the invalidate-all walk runs
    assert_no_accept_walk_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |-> !walking_q);

    // R14: a normal command answers in the following cycle
    assert_rsp_next_R14: assert property (@(posedge clk) disable iff (rst)
        (accept && op != OP_INVAL_ALL) |=> (rsp_valid && rsp_last));

    // R8: non-cacheable addressed commands bypass
    assert_nc_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && nc && op inside {OP_READ, OP_WRITE, OP_LOCK, OP_UNLOCK, OP_INVAL})
        |=> (rsp_bypass && !rsp_hit && !rsp_alloc));

    // R5: ranks in the addressed set never exceed the way count
    for (genvar w = 0; w < WAYS; w++) begin : g_rank_chk
        assert_rank_range_R5: assert property (@(posedge clk) disable iff (rst)
            s_rank[w] <= RANK_W'(WAYS));
    end

endmodule

// File: tb/ctag_array_bench.sv
`timescale 1ns/1ps
module ctag_array_bench;
    localparam int SETS = 16, WAYS = 4, LINE = 32;
    localparam int OFF_W = 5, SET_W = 4, TAG_W = 23;

    logic        clk = 1'b0, rst = 1'b1;
    logic        cmd_valid = 1'b0, cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_addr = '0;
    logic        cmd_flush = 1'b0, cache_dis = 1'b0, cb_mode = 1'b1;
    logic        rsp_valid, rsp_hit, rsp_bypass, rsp_alloc, rsp_wb, rsp_last;
    logic [1:0]  rsp_way;
    logic [31:0] rsp_wb_addr;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    ctag_array #(.SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE)) u_ctag_array (
        .clk, .rst, .cmd_valid, .cmd_ready, .cmd_op, .cmd_addr, .cmd_flush,
        .cache_dis, .cb_mode, .rsp_valid, .rsp_hit, .rsp_bypass, .rsp_alloc,
        .rsp_way, .rsp_wb, .rsp_wb_addr, .rsp_last
    );

    // reference model
    bit               m_v [SETS][WAYS];
    bit               m_d [SETS][WAYS];
    bit               m_l [SETS][WAYS];
    int               m_r [SETS][WAYS];
    logic [TAG_W-1:0] m_t [SETS][WAYS];

    task automatic m_mru(int s, int w);
        int r = m_r[s][w];
        for (int x = 0; x < WAYS; x++) if (m_r[s][x] > r) m_r[s][x]--;
        m_r[s][w] = WAYS;
    endtask

    task automatic m_inv(int s, int w);
        int r = m_r[s][w];
        for (int x = 0; x < WAYS; x++)
            if (x != w && m_r[s][x] != 0 && m_r[s][x] < r) m_r[s][x]++;
        m_r[s][w] = 0;
    endtask

    // expected packing: {hit, bypass, alloc, way[1:0], wb, wbaddr[31:0], last}
    function automatic logic [38:0] pack(bit h, bit b, bit a, int w, bit wb, logic [31:0] wa, bit l);
        return {h, b, a, 2'(w), wb, wa, l};
    endfunction

    task automatic m_exec(int op, logic [31:0] addr, bit fl, bit dis, bit cb,
                          output logic [38:0] exp);
        int s = int'(addr[OFF_W +: SET_W]);
        logic [TAG_W-1:0] t = addr[31 -: TAG_W];
        bit nc = dis || (addr >= 32'hFE00_0000);
        int hw = -1, vw = -1, best = 0;
        for (int w = 0; w < WAYS; w++) if (m_v[s][w] && m_t[s][w] == t && hw < 0) hw = w;
        for (int w = 0; w < WAYS; w++)
            if (!m_l[s][w] && (vw < 0 || m_r[s][w] < best)) begin vw = w; best = m_r[s][w]; end
        exp = pack(0, 0, 0, 0, 0, 0, 1);
        if (nc) begin exp = pack(0, 1, 0, 0, 0, 0, 1); return; end
        case (op)
            0, 1, 2: begin
                if (hw >= 0) begin
                    if (op == 1 && cb) m_d[s][hw] = 1;
                    if (op == 2) m_l[s][hw] = 1;
                    m_mru(s, hw);
                    exp = pack(1, 0, 0, hw, 0, 0, 1);
                end else if (vw >= 0 && (op != 1 || cb)) begin
                    bit wb = m_v[s][vw] && m_d[s][vw] && cb;
                    logic [31:0] wa = wb ? {m_t[s][vw], 4'(s), 5'd0} : 32'd0;
                    m_v[s][vw] = 1; m_d[s][vw] = (op == 1); m_l[s][vw] = (op == 2);
                    m_t[s][vw] = t;
                    m_mru(s, vw);
                    exp = pack(0, 0, 1, vw, wb, wa, 1);
                end else exp = pack(0, 1, 0, 0, 0, 0, 1);
            end
            3: if (hw >= 0) begin m_l[s][hw] = 0; exp = pack(1, 0, 0, hw, 0, 0, 1); end
            4: if (hw >= 0) begin
                bit wb = m_d[s][hw] && fl;
                exp = pack(1, 0, 0, hw, wb, wb ? {t, 4'(s), 5'd0} : 32'd0, 1);
                m_inv(s, hw);
                m_v[s][hw] = 0; m_d[s][hw] = 0; m_l[s][hw] = 0;
            end
            default: ;
        endcase
    endtask

    function automatic logic [38:0] actual();
        return {rsp_hit, rsp_bypass, rsp_alloc, rsp_way, rsp_wb, rsp_wb_addr, rsp_last};
    endfunction

    task automatic check(bit ok, string req, logic [38:0] got, logic [38:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic do_cmd(int op, logic [31:0] addr, bit fl, bit dis, bit cb, string req);
        logic [38:0] exp;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); cmd_addr = addr;
        cmd_flush = fl; cache_dis = dis; cb_mode = cb;
        @(negedge clk);
        cmd_valid = 0;
        if (op == 5) begin
            // R7: nothing in the acceptance-following cycle, then one beat per line
            check(!rsp_valid && !cmd_ready, "R7", {37'd0, rsp_valid, cmd_ready}, '0);
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    bit wb = m_v[s][w] && m_d[s][w] && fl;
                    bit lst = (s == SETS - 1) && (w == WAYS - 1);
                    exp = pack(0, 0, 0, w, wb, wb ? {m_t[s][w], 4'(s), 5'd0} : 32'd0, lst);
                    m_v[s][w] = 0; m_d[s][w] = 0; m_l[s][w] = 0; m_r[s][w] = 0;
                    @(negedge clk);
                    check(rsp_valid && actual() == exp && (cmd_ready == lst), req, actual(), exp);
                end
            end
        end else begin
            m_exec(op, addr, fl, dis, cb, exp);
            check(rsp_valid && actual() == exp, req, actual(), exp);   // R14 timing
        end
    endtask

    function automatic logic [31:0] mk(int tagv, int s, int off);
        return {23'(tagv), 4'(s), 5'(off)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_v[s][w] = 0; m_d[s][w] = 0; m_l[s][w] = 0; m_r[s][w] = 0; m_t[s][w] = '0;
            end
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        // R13: reset state
        check(cmd_ready && !rsp_valid, "R13", {37'd0, cmd_ready, rsp_valid}, 39'd2);

        // R1 R2 R13: first miss takes way 0, then hit
        do_cmd(0, mk(5, 1, 3), 0, 0, 1, "R2");
        do_cmd(0, mk(5, 1, 30), 0, 0, 1, "R1");
        // R3 R5: fill the set, recency order decides victims
        do_cmd(0, mk(6, 1, 0), 0, 0, 1, "R3");
        do_cmd(0, mk(7, 1, 0), 0, 0, 1, "R3");
        do_cmd(0, mk(8, 1, 0), 0, 0, 1, "R3");
        do_cmd(0, mk(5, 1, 0), 0, 0, 1, "R5");
        do_cmd(0, mk(9, 1, 0), 0, 0, 1, "R5");
        // R9 R10: dirty a line then evict it
        do_cmd(1, mk(7, 1, 4), 0, 0, 1, "R9");
        do_cmd(1, mk(10, 1, 4), 0, 0, 0, "R9");
        do_cmd(0, mk(11, 1, 0), 0, 0, 1, "R10");
        do_cmd(0, mk(12, 1, 0), 0, 0, 1, "R10");
        do_cmd(1, mk(13, 1, 0), 0, 0, 1, "R9");
        do_cmd(0, mk(14, 1, 0), 0, 0, 0, "R10");
        // R6: invalidate with and without flush
        do_cmd(1, mk(20, 2, 0), 0, 0, 1, "R6");
        do_cmd(0, mk(21, 2, 0), 0, 0, 1, "R6");
        do_cmd(4, mk(20, 2, 8), 1, 0, 1, "R6");
        do_cmd(4, mk(20, 2, 8), 1, 0, 1, "R6");
        do_cmd(0, mk(22, 2, 0), 0, 0, 1, "R6");
        // R12 R4: lock all ways, a miss must bypass
        do_cmd(2, mk(30, 3, 0), 0, 0, 1, "R12");
        do_cmd(2, mk(31, 3, 0), 0, 0, 1, "R12");
        do_cmd(2, mk(32, 3, 0), 0, 0, 1, "R12");
        do_cmd(2, mk(33, 3, 0), 0, 0, 1, "R12");
        do_cmd(0, mk(34, 3, 0), 0, 0, 1, "R4");
        do_cmd(1, mk(34, 3, 0), 0, 0, 1, "R4");
        do_cmd(0, mk(30, 3, 0), 0, 0, 1, "R4");
        // R11: unlock miss has no effect, unlock hit frees the way
        do_cmd(3, mk(35, 3, 0), 0, 0, 1, "R11");
        do_cmd(0, mk(34, 3, 0), 0, 0, 1, "R11");
        do_cmd(3, mk(31, 3, 0), 0, 0, 1, "R11");
        do_cmd(0, mk(34, 3, 0), 0, 0, 1, "R11");
        // R8: non-cacheable region and global disable
        do_cmd(0, 32'hFE00_0000, 0, 0, 1, "R8");
        do_cmd(1, 32'hFFFF_FFE0, 0, 0, 1, "R8");
        do_cmd(0, 32'hFDFF_FFE0, 0, 0, 1, "R8");
        do_cmd(4, mk(5, 1, 0), 1, 1, 1, "R8");
        do_cmd(0, mk(5, 1, 0), 0, 0, 1, "R8");
        // R7: invalidate-all with flush
        do_cmd(5, 32'h0, 1, 0, 1, "R7");
        do_cmd(0, mk(30, 3, 0), 0, 0, 1, "R7");

        // random phase over a tight address pool
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            int k = int'($urandom_range(99));
            int op = (k < 35) ? 0 : (k < 60) ? 1 : (k < 70) ? 2 : (k < 80) ? 3 : (k < 98) ? 4 : 5;
            logic [31:0] a = mk(int'($urandom_range(5)) + 40, int'($urandom_range(3)),
                                int'($urandom_range(31)));
            if ($urandom_range(19) == 0) a = 32'hFE00_0000 + $urandom_range(32'h00FF_FFFF);
            do_cmd(op, a, 1'($urandom_range(1)), ($urandom_range(15) == 0),
                   1'($urandom_range(3) != 0), "R1");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule